// File: doc/BRIEF.md
# Standby Entry and Wake Sequencer

This block decides when a small microcontroller drops into its deepest standby state and how it comes back out. A one-cycle sleep strobe from the CPU is honoured as a standby request only when three configuration bits agree: deep standby selected, low-speed operation off, and the watchdog divider-select bit clear. In standby the oscillator enable and the clock-gate enable both drop. On the way in, the volatile peripherals (serial, converter, motor and general PWM, CAN controller, port logic) receive a one-cycle state-clear pulse. All other module state is kept.

Wake-up comes from the non-maskable interrupt, from one of six external interrupt lines, or from the reset pin. An interrupt wake restarts the oscillator at once. It keeps the clocks gated for a settling interval chosen by a 3-bit setting, then restores the clocks and raises an interrupt-exception request. A reset-pin wake restores the oscillator and clocks on the next cycle with no settling wait. It then holds the CPU in reset until the pin returns high. A 2-bit wake-cause code stays valid until the CPU acknowledges it.

Top module: `pwrmode_seq`

## Requirements
- R1: When `sleep_req` is 1 while `cfg_deep_sel`=1, `cfg_slow_on`=0 and `cfg_wdt_div_sel`=0 in the run state, `osc_en` and `clk_en` are both 0 from the next cycle.
- R2: A `sleep_req` with any of those three bits at its other value leaves `osc_en`=1 and `clk_en`=1, and produces no `periph_clr`.
- R3: `periph_clr` is 1 for exactly the first cycle of standby, and is 0 at all other times.
- R4: In standby, line k of `irq_in` wakes the block only if `irq_en[k]`=1, `irq_cpu_mask[k]`=0 and `irq_dma_sel[k]`=0. An unqualified line leaves `osc_en` at 0.
- R5: `nmi_in` wakes the block whatever the interrupt-line qualifiers are. When it arrives together with a qualified line, the recorded cause is NMI.
- R6: After an interrupt wake, `osc_en`=1 and `clk_en`=0 for exactly 2^(SETTLE_BASE_LOG2+`settle_sel`) cycles. After that, `clk_en`=1 and `wake_irq_req` is 1 for one cycle.
- R7: NMI or interrupt-line events during the settling interval neither restart the count nor change the recorded cause.
- R8: `rst_pin_n`=0 during standby or settling gives `osc_en`=1, `clk_en`=1 and `cpu_rst_hold`=1 from the next cycle. `cpu_rst_hold` stays 1 while the pin is low and drops one cycle after the pin goes high.
- R9: `wake_cause` encodes 0 none, 1 NMI, 2 interrupt line, 3 reset pin. It is loaded when the block returns to run and holds its value until `cause_ack`=1, which clears it to 0 on the next cycle.
- R10: After `rst`, the block is in run with `osc_en`=1, `clk_en`=1, `wake_cause`=0, and `periph_clr`, `wake_irq_req` and `cpu_rst_hold` all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| sleep_req | input | 1 | One-cycle sleep strobe from the CPU |
| cfg_deep_sel | input | 1 | Deep standby selected |
| cfg_slow_on | input | 1 | Low-speed operation enabled |
| cfg_wdt_div_sel | input | 1 | Watchdog divider-select bit |
| settle_sel | input | 3 | Oscillator settling interval select |
| nmi_in | input | 1 | Non-maskable interrupt request |
| irq_in | input | 6 | External interrupt lines |
| irq_en | input | 6 | Per-line wake enable |
| irq_cpu_mask | input | 6 | Per-line CPU-side mask |
| irq_dma_sel | input | 6 | Per-line assignment as a DMA-controller trigger |
| rst_pin_n | input | 1 | Reset pin, active low |
| cause_ack | input | 1 | CPU acknowledge of the wake cause |
| osc_en | output | 1 | Oscillator enable |
| clk_en | output | 1 | CPU and peripheral clock-gate enable |
| periph_clr | output | 1 | State-clear pulse for the volatile peripherals |
| wake_irq_req | output | 1 | Interrupt-exception request after settling |
| cpu_rst_hold | output | 1 | Holds the CPU in reset during a reset-pin wake |
| wake_cause | output | 2 | Recorded wake cause |

## Verification
The bench turns off each of the three entry bits in turn. A design that checks only some of them would gate the clocks and pulse the peripheral clear when it should not. It wakes on interrupt lines that fail one qualifier each, where a loose qualifier would start the oscillator early. It also sends NMI alone and together with a qualified line, where wrong priority would record the cause as an interrupt line. It counts the gated cycles at several settle selections and injects new wake events in the middle of settling. An off-by-one count, or a count that restarts, would change the measured length. Reset-pin wakes from standby and from mid-settle check that clocks return without waiting and that the CPU stays held until the pin is released.

// File: rtl/pwrmode_pkg.sv
package pwrmode_pkg;

    localparam int IRQ_LINES = 6;
    localparam int SEL_W     = 3;

    typedef enum logic [1:0] {
        PM_RUN    = 2'd0,
        PM_STBY   = 2'd1,
        PM_SETTLE = 2'd2,
        PM_RSTWK  = 2'd3
    } pm_state_t;

    typedef enum logic [1:0] {
        WC_NONE = 2'd0,
        WC_NMI  = 2'd1,
        WC_IRQ  = 2'd2,
        WC_RST  = 2'd3
    } wake_cause_t;

    typedef struct packed {
        logic nmi_hit;
        logic irq_hit;
    } wake_hits_t;

    function automatic int settle_width(input int base_log2);
        return base_log2 + (1 << SEL_W);
    endfunction

endpackage

// File: rtl/pwrmode_wake_qual.sv
module pwrmode_wake_qual
    import pwrmode_pkg::*;
#(
    parameter int LINES = IRQ_LINES
) (
    input  logic             nmi_in,
    input  logic [LINES-1:0] irq_in,
    input  logic [LINES-1:0] irq_en,
    input  logic [LINES-1:0] irq_cpu_mask,
    input  logic [LINES-1:0] irq_dma_sel,
    output wake_hits_t       hits
);

    logic [LINES-1:0] line_ok;

    for (genvar k = 0; k < LINES; k++) begin : g_line
        assign line_ok[k] = irq_in[k] & irq_en[k] & ~irq_cpu_mask[k] & ~irq_dma_sel[k];
    end

    always_comb begin
        hits.nmi_hit = nmi_in;
        hits.irq_hit = |line_ok;
    end

endmodule

// File: rtl/pwrmode_settle_timer.sv
module pwrmode_settle_timer
    import pwrmode_pkg::*;
#(
    parameter int BASE_LOG2 = 3,
    localparam int CW = settle_width(BASE_LOG2)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [SEL_W-1:0] sel,
    input  logic             run,
    output logic             done
);

    logic [CW-1:0] cnt;
    logic [CW-1:0] load_val;

    always_comb begin
        load_val = (CW'(1) << (BASE_LOG2 + int'(sel))) - CW'(1);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val;
        end else if (run && cnt != '0) begin
            cnt <= cnt - CW'(1);
        end
    end

    assign done = run && (cnt == '0);

endmodule

// File: rtl/pwrmode_cause_reg.sv
module pwrmode_cause_reg
    import pwrmode_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        set,
    input  wake_cause_t set_val,
    input  logic        ack,
    output wake_cause_t cause
);

    always_ff @(posedge clk) begin
        if (rst) begin
            cause <= WC_NONE;
        end else if (set) begin
            cause <= set_val;
        end else if (ack) begin
            cause <= WC_NONE;
        end
    end

endmodule

// File: rtl/pwrmode_seq.sv
module pwrmode_seq
    import pwrmode_pkg::*;
#(
    parameter int SETTLE_BASE_LOG2 = 3,
    parameter int LINES = IRQ_LINES
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             sleep_req,
    input  logic             cfg_deep_sel,
    input  logic             cfg_slow_on,
    input  logic             cfg_wdt_div_sel,
    input  logic [SEL_W-1:0] settle_sel,
    input  logic             nmi_in,
    input  logic [LINES-1:0] irq_in,
    input  logic [LINES-1:0] irq_en,
    input  logic [LINES-1:0] irq_cpu_mask,
    input  logic [LINES-1:0] irq_dma_sel,
    input  logic             rst_pin_n,
    input  logic             cause_ack,
    output logic             osc_en,
    output logic             clk_en,
    output logic             periph_clr,
    output logic             wake_irq_req,
    output logic             cpu_rst_hold,
    output logic [1:0]       wake_cause
);

    pm_state_t   state, state_nxt;
    wake_cause_t pend, pend_nxt;
    wake_cause_t cause_q, cause_set_val;
    wake_hits_t  hits;
    logic        entry_ok;
    logic        tmr_load, tmr_done;
    logic        cause_set;
    logic        irq_pulse_nxt;

    pwrmode_wake_qual #(.LINES(LINES)) u_qual (
        .nmi_in       (nmi_in),
        .irq_in       (irq_in),
        .irq_en       (irq_en),
        .irq_cpu_mask (irq_cpu_mask),
        .irq_dma_sel  (irq_dma_sel),
        .hits         (hits)
    );

    pwrmode_settle_timer #(.BASE_LOG2(SETTLE_BASE_LOG2)) u_timer (
        .clk  (clk),
        .rst  (rst),
        .load (tmr_load),
        .sel  (settle_sel),
        .run  (state == PM_SETTLE),
        .done (tmr_done)
    );

    pwrmode_cause_reg u_cause (
        .clk     (clk),
        .rst     (rst),
        .set     (cause_set),
        .set_val (cause_set_val),
        .ack     (cause_ack),
        .cause   (cause_q)
    );

    assign entry_ok = sleep_req & cfg_deep_sel & ~cfg_slow_on & ~cfg_wdt_div_sel;

    always_comb begin
        state_nxt     = state;
        pend_nxt      = pend;
        tmr_load      = 1'b0;
        cause_set     = 1'b0;
        cause_set_val = WC_NONE;
        irq_pulse_nxt = 1'b0;
        unique case (state)
            PM_RUN: begin
                if (entry_ok) state_nxt = PM_STBY;
            end
            PM_STBY: begin
                if (!rst_pin_n) begin
                    state_nxt = PM_RSTWK;
                end else if (hits.nmi_hit || hits.irq_hit) begin
                    state_nxt = PM_SETTLE;
                    tmr_load  = 1'b1;
                    pend_nxt  = hits.nmi_hit ? WC_NMI : WC_IRQ;
                end
            end
            PM_SETTLE: begin
                if (!rst_pin_n) begin
                    state_nxt = PM_RSTWK;
                end else if (tmr_done) begin
                    state_nxt     = PM_RUN;
                    cause_set     = 1'b1;
                    cause_set_val = pend;
                    irq_pulse_nxt = 1'b1;
                end
            end
            PM_RSTWK: begin
                if (rst_pin_n) begin
                    state_nxt     = PM_RUN;
                    cause_set     = 1'b1;
                    cause_set_val = WC_RST;
                end
            end
            default: state_nxt = PM_RUN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state        <= PM_RUN;
            pend         <= WC_NONE;
            periph_clr   <= 1'b0;
            wake_irq_req <= 1'b0;
        end else begin
            state        <= state_nxt;
            pend         <= pend_nxt;
            periph_clr   <= (state == PM_RUN) && entry_ok;
            wake_irq_req <= irq_pulse_nxt;
        end
    end

    assign osc_en       = (state != PM_STBY);
    assign clk_en       = (state == PM_RUN) || (state == PM_RSTWK);
    assign cpu_rst_hold = (state == PM_RSTWK);
    assign wake_cause   = cause_q;

endmodule

// File: rtl/pwrmode_seq_chk.sv
module pwrmode_seq_chk (
    input logic       clk,
    input logic       rst,
    input logic       sleep_req,
    input logic       cfg_deep_sel,
    input logic       cfg_slow_on,
    input logic       cfg_wdt_div_sel,
    input logic       rst_pin_n,
    input logic       cause_ack,
    input logic       osc_en,
    input logic       clk_en,
    input logic       periph_clr,
    input logic       wake_irq_req,
    input logic       cpu_rst_hold,
    input logic [1:0] wake_cause
);

    logic in_run;
    assign in_run = clk_en && !cpu_rst_hold;

    assert_enter_standby_R1: assert property (@(posedge clk) disable iff (rst)
        (in_run && sleep_req && cfg_deep_sel && !cfg_slow_on && !cfg_wdt_div_sel)
        |=> (!osc_en && !clk_en && periph_clr));

    assert_no_entry_R2: assert property (@(posedge clk) disable iff (rst)
        (in_run && sleep_req && !(cfg_deep_sel && !cfg_slow_on && !cfg_wdt_div_sel))
        |=> (osc_en && clk_en && !periph_clr));

    assert_clr_single_R3: assert property (@(posedge clk) disable iff (rst)
        periph_clr |=> !periph_clr);

    assert_clr_gated_R3: assert property (@(posedge clk) disable iff (rst)
        periph_clr |-> (!clk_en && !osc_en));

    assert_clk_needs_osc_R6: assert property (@(posedge clk) disable iff (rst)
        clk_en |-> osc_en);

    assert_irq_req_cause_R6: assert property (@(posedge clk) disable iff (rst)
        wake_irq_req |-> (in_run && (wake_cause == 2'd1 || wake_cause == 2'd2)));

    assert_reset_wake_R8: assert property (@(posedge clk) disable iff (rst)
        (!osc_en && !rst_pin_n) |=> (cpu_rst_hold && clk_en && osc_en));

    assert_reset_release_R8: assert property (@(posedge clk) disable iff (rst)
        (cpu_rst_hold && rst_pin_n) |=> (!cpu_rst_hold && wake_cause == 2'd3));

    assert_cause_hold_R9: assert property (@(posedge clk) disable iff (rst)
        (in_run && !cause_ack) |=> $stable(wake_cause));

endmodule

bind pwrmode_seq pwrmode_seq_chk u_chk (
    .clk             (clk),
    .rst             (rst),
    .sleep_req       (sleep_req),
    .cfg_deep_sel    (cfg_deep_sel),
    .cfg_slow_on     (cfg_slow_on),
    .cfg_wdt_div_sel (cfg_wdt_div_sel),
    .rst_pin_n       (rst_pin_n),
    .cause_ack       (cause_ack),
    .osc_en          (osc_en),
    .clk_en          (clk_en),
    .periph_clr      (periph_clr),
    .wake_irq_req    (wake_irq_req),
    .cpu_rst_hold    (cpu_rst_hold),
    .wake_cause      (wake_cause)
);

// File: tb/pwrmode_seq_tb.sv
`timescale 1ns/1ps
module pwrmode_seq_tb;

    localparam int BASE = 1;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       sleep_req = 1'b0;
    logic       cfg_deep_sel = 1'b1;
    logic       cfg_slow_on = 1'b0;
    logic       cfg_wdt_div_sel = 1'b0;
    logic [2:0] settle_sel = 3'd0;
    logic       nmi_in = 1'b0;
    logic [5:0] irq_in = '0;
    logic [5:0] irq_en = '1;
    logic [5:0] irq_cpu_mask = '0;
    logic [5:0] irq_dma_sel = '0;
    logic       rst_pin_n = 1'b1;
    logic       cause_ack = 1'b0;
    logic       osc_en, clk_en, periph_clr, wake_irq_req, cpu_rst_hold;
    logic [1:0] wake_cause;

    int n_tests = 0;
    int n_fail  = 0;
    int cyc     = 0;

    always #2.5 clk = ~clk;

    pwrmode_seq #(.SETTLE_BASE_LOG2(BASE)) u_dut (
        .clk(clk), .rst(rst), .sleep_req(sleep_req),
        .cfg_deep_sel(cfg_deep_sel), .cfg_slow_on(cfg_slow_on),
        .cfg_wdt_div_sel(cfg_wdt_div_sel), .settle_sel(settle_sel),
        .nmi_in(nmi_in), .irq_in(irq_in), .irq_en(irq_en),
        .irq_cpu_mask(irq_cpu_mask), .irq_dma_sel(irq_dma_sel),
        .rst_pin_n(rst_pin_n), .cause_ack(cause_ack),
        .osc_en(osc_en), .clk_en(clk_en), .periph_clr(periph_clr),
        .wake_irq_req(wake_irq_req), .cpu_rst_hold(cpu_rst_hold),
        .wake_cause(wake_cause)
    );

    task automatic check(input string req, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic enter_standby();
        @(negedge clk);
        cfg_deep_sel = 1'b1; cfg_slow_on = 1'b0; cfg_wdt_div_sel = 1'b0;
        sleep_req = 1'b1;
        @(negedge clk);
        sleep_req = 1'b0;
        check("R1 osc_en off", int'(osc_en), 0);
        check("R1 clk_en off", int'(clk_en), 0);
        check("R3 clear pulse", int'(periph_clr), 1);
        @(negedge clk);
        check("R3 clear single", int'(periph_clr), 0);
    endtask

    task automatic ack_cause();
        cause_ack = 1'b1;
        @(negedge clk);
        cause_ack = 1'b0;
        check("R9 ack clears", int'(wake_cause), 0);
    endtask

    // Inputs set by caller at a negedge; counts settle cycles then checks exit.
    task automatic measure_settle(output int n);
        n = 0;
        for (int i = 0; i < 5000; i++) begin
            @(negedge clk);
            nmi_in = 1'b0; irq_in = '0;
            if (clk_en) break;
            if (osc_en) n++;
        end
    endtask

    task automatic t_reset();
        check("R10 osc_en", int'(osc_en), 1);
        check("R10 clk_en", int'(clk_en), 1);
        check("R10 cause", int'(wake_cause), 0);
        check("R10 clr", int'(periph_clr), 0);
        check("R10 irq_req", int'(wake_irq_req), 0);
        check("R10 hold", int'(cpu_rst_hold), 0);
    endtask

    task automatic t_no_entry();
        for (int v = 0; v < 3; v++) begin
            @(negedge clk);
            cfg_deep_sel = (v != 0); cfg_slow_on = (v == 1); cfg_wdt_div_sel = (v == 2);
            sleep_req = 1'b1;
            @(negedge clk);
            sleep_req = 1'b0;
            check("R2 clk_en stays", int'(clk_en), 1);
            check("R2 osc_en stays", int'(osc_en), 1);
            check("R2 no clear", int'(periph_clr), 0);
        end
        cfg_deep_sel = 1'b1; cfg_slow_on = 1'b0; cfg_wdt_div_sel = 1'b0;
    endtask

    task automatic t_irq_qual();
        int n;
        enter_standby();
        for (int v = 0; v < 3; v++) begin
            irq_en = '1; irq_cpu_mask = '0; irq_dma_sel = '0;
            if (v == 0) irq_en[2] = 1'b0;
            if (v == 1) irq_cpu_mask[2] = 1'b1;
            if (v == 2) irq_dma_sel[2] = 1'b1;
            irq_in[2] = 1'b1;
            repeat (3) @(negedge clk);
            check("R4 unqualified ignored", int'(osc_en), 0);
            irq_in = '0;
        end
        irq_en = '1; irq_cpu_mask = '0; irq_dma_sel = '0;
        settle_sel = 3'd2;
        irq_in[4] = 1'b1;
        measure_settle(n);
        check("R6 settle length sel2", n, 1 << (BASE + 2));
        check("R6 irq request", int'(wake_irq_req), 1);
        check("R4 cause irq", int'(wake_cause), 2);
        @(negedge clk);
        check("R6 irq request single", int'(wake_irq_req), 0);
        ack_cause();
    endtask

    task automatic t_nmi();
        int n;
        enter_standby();
        irq_en = '0; irq_cpu_mask = '1; irq_dma_sel = '1;
        settle_sel = 3'd0;
        nmi_in = 1'b1;
        measure_settle(n);
        check("R6 settle length sel0", n, 1 << BASE);
        check("R5 cause nmi", int'(wake_cause), 1);
        ack_cause();
        irq_en = '1; irq_cpu_mask = '0; irq_dma_sel = '0;
        enter_standby();
        settle_sel = 3'd7;
        nmi_in = 1'b1; irq_in[0] = 1'b1;
        measure_settle(n);
        check("R6 settle length sel7", n, 1 << (BASE + 7));
        check("R5 nmi beats irq", int'(wake_cause), 1);
        ack_cause();
    endtask

    task automatic t_settle_latched();
        int n;
        enter_standby();
        settle_sel = 3'd3;
        irq_in[1] = 1'b1;
        n = 0;
        for (int i = 0; i < 5000; i++) begin
            @(negedge clk);
            nmi_in = 1'b0; irq_in = '0;
            if (i == 6) begin nmi_in = 1'b1; irq_in[3] = 1'b1; end
            if (clk_en) break;
            if (osc_en) n++;
        end
        check("R7 count not restarted", n, 1 << (BASE + 3));
        check("R7 cause unchanged", int'(wake_cause), 2);
        ack_cause();
    endtask

    task automatic t_reset_wake();
        int n;
        enter_standby();
        rst_pin_n = 1'b0;
        @(negedge clk);
        check("R8 osc at once", int'(osc_en), 1);
        check("R8 clk at once", int'(clk_en), 1);
        check("R8 hold", int'(cpu_rst_hold), 1);
        repeat (3) @(negedge clk);
        check("R8 hold while low", int'(cpu_rst_hold), 1);
        rst_pin_n = 1'b1;
        @(negedge clk);
        check("R8 hold released", int'(cpu_rst_hold), 0);
        check("R9 cause reset", int'(wake_cause), 3);
        ack_cause();
        enter_standby();
        settle_sel = 3'd4;
        irq_in[5] = 1'b1;
        @(negedge clk);
        irq_in = '0;
        check("R6 mid settle gated", int'(clk_en), 0);
        rst_pin_n = 1'b0;
        @(negedge clk);
        check("R8 reset in settle", int'(cpu_rst_hold & clk_en), 1);
        rst_pin_n = 1'b1;
        @(negedge clk);
        check("R8 release from settle", int'(cpu_rst_hold), 0);
        check("R9 cause reset over irq", int'(wake_cause), 3);
        ack_cause();
    endtask

    task automatic t_cause_hold();
        int n;
        enter_standby();
        settle_sel = 3'd1;
        nmi_in = 1'b1;
        measure_settle(n);
        repeat (5) @(negedge clk);
        check("R9 cause held", int'(wake_cause), 1);
        ack_cause();
        repeat (2) @(negedge clk);
        check("R9 stays none", int'(wake_cause), 0);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc == 100000) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_no_entry();
        t_irq_qual();
        t_nmi();
        t_settle_latched();
        t_reset_wake();
        t_cause_hold();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule